// File: doc/BRIEF.md
# Refresh Counter Self-Test Sequencer

This block is a built-in test engine that sits in front of an asynchronous DRAM strobe interface (row strobe, column strobe, write enable, multiplexed address, one data bit in each direction). Its purpose is to confirm that the memory's internal CAS-before-RAS refresh address counter steps through every row exactly once. A single `start_i` pulse launches a fixed procedure. The procedure primes the counter with a burst of RAS-only cycles. It then fills every row at one fixed column with a background bit. Next it runs one counter-addressed read-modify-write per row. In that cycle a CAS-before-RAS refresh is followed by a second CAS fall while RAS stays low: the bit is read and checked, then its complement is written back. A normal read-back of every row closes the pass. The whole procedure then repeats with the opposite background.

Every strobe level is held for a programmable number of clocks, so the analog spacing rules of the memory reduce to picking `STEP_CYC` for the clock rate. The engine halts on the first mismatch. It raises `done_o` together with `fail_o` and reports the phase, the pass and the row index where the mismatch was seen. A stuck, frozen or skipping counter makes the read-modify-write phase revisit a row it has already inverted. The index reported in that phase is therefore the iteration number within the phase.

Top module: `refctr_test_seq`

## Requirements
- R1: After reset the RAS, CAS and WE outputs are high (inactive), and `done_o` and `fail_o` are low.
- R2: Each pass begins with `INIT_CYC` (default 8) RAS-only cycles. In each one RAS falls while CAS is high, and the row addresses run 0, 1, 2 and up.
- R3: Every CAS fall that happens while RAS is low presents the column address `TEST_COL` on `addr_o`.
- R4: The fill phase issues one early-write cycle per row, rows 0 to 2^ROW_W-1. WE falls before CAS, and the written bit is the background: 0 in the first pass, 1 in the second.
- R5: The counter phase issues 2^ROW_W counter-test cycles. In each, CAS falls while RAS is high. RAS then falls with WE high. CAS rises and falls again with RAS low, and the bit read there is compared with the background. WE then falls to write the complement.
- R6: The check phase issues one normal read cycle per row (WE high at the CAS fall) and expects the complement of the background.
- R7: The second pass uses inverted data. A run with no mismatch ends with `done_o`=1 and `fail_o`=0, and every tested cell then holds 0.
- R8: On the first mismatch the engine closes the current cycle with all strobes high, then stops. It sets `done_o`=1 and `fail_o`=1. `fail_phase_o` is 2 for the counter phase and 3 for the check phase. `fail_pass_o` is 0 or 1. `fail_row_o` is the iteration index in the counter phase and the row address in the check phase.
- R9: While done, the results hold. A new `start_i` clears `done_o` and `fail_o` on the next clock and runs the procedure again.
- R10: No strobe output changes within fewer than `STEP_CYC` clocks of a previous change of any strobe output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the procedure (taken when idle) |
| dout_i | input | 1 | Data bit read from the memory |
| done_o | output | 1 | Procedure finished |
| fail_o | output | 1 | A mismatch was found |
| fail_phase_o | output | 2 | Phase of the mismatch (2 counter, 3 check) |
| fail_pass_o | output | 1 | Pass of the mismatch |
| fail_row_o | output | ROW_W | Iteration index or row of the mismatch |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Multiplexed row/column address |
| din_o | output | 1 | Data bit written to the memory |

## Verification
The bench drives a behavioural memory whose refresh counter starts at a random row. The memory can carry an injected fault: a counter bit stuck at zero, a counter that never advances, or a single cell stuck at 1 or at 0. A sequencer that ignored the counter and addressed rows itself would miss the counter faults. One that checked only in the final read would report the wrong phase. One that did not stop would overwrite the first failing index. A counter-test cycle with WE low at the RAS fall would enter test mode in the memory, and the model flags this. The clean run counts each kind of memory cycle and the data written in it, so a miscount in either pass, or a second pass with the background left uninverted, is detected.

// File: rtl/refctr_pkg.sv
package refctr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ROW,
        ST_RASLO,
        ST_COL,
        ST_CASLO,
        ST_CBR_CAS,
        ST_CBR_RAS,
        ST_CAS_UP,
        ST_CAS_LO2,
        ST_WR,
        ST_PRE
    } step_e;

    // Phase codes are reported on fail_phase_o.
    typedef enum logic [1:0] {
        PH_INIT  = 2'd0,
        PH_FILL  = 2'd1,
        PH_RMW   = 2'd2,
        PH_CHECK = 2'd3
    } phase_e;

endpackage

// File: rtl/refctr_step_timer.sv
module refctr_step_timer #(
    parameter int STEP_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic step_end
);
    localparam int CW = (STEP_CYC < 2) ? 1 : $clog2(STEP_CYC);
    localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        step_end = run && (cnt_q == LAST);
        if (!run || step_end) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // A step never outlasts its programmed length (R10).
    assert_step_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != LAST) |=> (cnt_q == '0 || cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/refctr_pin_drive.sv
module refctr_pin_drive
    import refctr_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int ROW_W    = 10,
    parameter int TEST_COL = 'h2A5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  step_e             st,
    input  phase_e            ph,
    input  logic [ROW_W-1:0]  idx,
    input  logic              bg,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              din_o
);
    localparam logic [ADDR_W-1:0] COL_A = ADDR_W'(TEST_COL);

    typedef struct packed {
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic [ADDR_W-1:0] addr;
        logic              din;
    } pins_s;

    pins_s pin_d, pin_q;
    logic  wr_val;
    logic  early_we_n;

    always_comb begin
        wr_val     = bg ^ (ph == PH_RMW);
        early_we_n = (ph != PH_FILL);
        pin_d      = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, addr: COL_A, din: 1'b0};
        unique case (st)
            ST_ROW:     pin_d.addr = ADDR_W'(idx);
            ST_RASLO: begin
                pin_d.ras_n = 1'b0;
                pin_d.addr  = ADDR_W'(idx);
            end
            ST_COL: begin
                pin_d.ras_n = 1'b0;
                pin_d.we_n  = early_we_n;
                pin_d.din   = wr_val;
            end
            ST_CASLO: begin
                pin_d.ras_n = 1'b0;
                pin_d.cas_n = 1'b0;
                pin_d.we_n  = early_we_n;
                pin_d.din   = wr_val;
            end
            ST_CBR_CAS: pin_d.cas_n = 1'b0;
            ST_CBR_RAS: begin
                pin_d.ras_n = 1'b0;
                pin_d.cas_n = 1'b0;
            end
            ST_CAS_UP:  pin_d.ras_n = 1'b0;
            ST_CAS_LO2: begin
                pin_d.ras_n = 1'b0;
                pin_d.cas_n = 1'b0;
                pin_d.din   = wr_val;
            end
            ST_WR: begin
                pin_d.ras_n = 1'b0;
                pin_d.cas_n = 1'b0;
                pin_d.we_n  = 1'b0;
                pin_d.din   = wr_val;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, addr: '0, din: 1'b0};
        else        pin_q <= pin_d;
    end

    assign ras_n_o = pin_q.ras_n;
    assign cas_n_o = pin_q.cas_n;
    assign we_n_o  = pin_q.we_n;
    assign addr_o  = pin_q.addr;
    assign din_o   = pin_q.din;

    // Counter-test cycles must not enter test mode (R5).
    assert_we_high_cbr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n_o) && !cas_n_o) |-> we_n_o);

    // Column strobe always latches the fixed test column (R3).
    assert_fixed_col_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n_o) && !ras_n_o) |-> (addr_o == COL_A));

    // A column strobe pulse is never a single clock wide (R10).
    assert_cas_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n_o) |=> !cas_n_o);

endmodule

// File: rtl/refctr_test_seq.sv
module refctr_test_seq
    import refctr_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int ROW_W    = 10,
    parameter int TEST_COL = 'h2A5,
    parameter int INIT_CYC = 8,
    parameter int STEP_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dout_i,
    output logic              done_o,
    output logic              fail_o,
    output logic [1:0]        fail_phase_o,
    output logic              fail_pass_o,
    output logic [ROW_W-1:0]  fail_row_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              din_o
);
    localparam logic [ROW_W-1:0] INIT_LAST = ROW_W'(INIT_CYC - 1);
    localparam logic [ROW_W-1:0] ROW_LAST  = {ROW_W{1'b1}};

    typedef struct packed {
        step_e            st;
        phase_e           ph;
        logic             pass;
        logic [ROW_W-1:0] idx;
        logic             done;
        logic             fail;
        phase_e           f_ph;
        logic             f_pass;
        logic [ROW_W-1:0] f_row;
    } seq_s;

    seq_s seq_d, seq_q;
    logic step_end;
    logic last_idx;

    refctr_step_timer #(.STEP_CYC(STEP_CYC)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (seq_q.st != ST_IDLE),
        .step_end (step_end)
    );

    always_comb begin
        seq_d    = seq_q;
        last_idx = (seq_q.ph == PH_INIT) ? (seq_q.idx == INIT_LAST) : (seq_q.idx == ROW_LAST);
        if (seq_q.st == ST_IDLE) begin
            if (start_i) begin
                seq_d      = '0;
                seq_d.st   = ST_ROW;
                seq_d.ph   = PH_INIT;
                seq_d.f_ph = PH_INIT;
            end
        end else if (step_end) begin
            unique case (seq_q.st)
                ST_ROW:     seq_d.st = ST_RASLO;
                ST_RASLO:   seq_d.st = (seq_q.ph == PH_INIT) ? ST_PRE : ST_COL;
                ST_COL:     seq_d.st = ST_CASLO;
                ST_CASLO: begin
                    seq_d.st = ST_PRE;
                    if (seq_q.ph == PH_CHECK && dout_i != !seq_q.pass) begin
                        seq_d.fail   = 1'b1;
                        seq_d.f_ph   = PH_CHECK;
                        seq_d.f_pass = seq_q.pass;
                        seq_d.f_row  = seq_q.idx;
                    end
                end
                ST_CBR_CAS: seq_d.st = ST_CBR_RAS;
                ST_CBR_RAS: seq_d.st = ST_CAS_UP;
                ST_CAS_UP:  seq_d.st = ST_CAS_LO2;
                ST_CAS_LO2: begin
                    if (dout_i != seq_q.pass) begin
                        seq_d.st     = ST_PRE;
                        seq_d.fail   = 1'b1;
                        seq_d.f_ph   = PH_RMW;
                        seq_d.f_pass = seq_q.pass;
                        seq_d.f_row  = seq_q.idx;
                    end else begin
                        seq_d.st = ST_WR;
                    end
                end
                ST_WR:      seq_d.st = ST_PRE;
                ST_PRE: begin
                    if (seq_q.fail) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end else if (!last_idx) begin
                        seq_d.idx = seq_q.idx + 1'b1;
                        seq_d.st  = (seq_q.ph == PH_RMW) ? ST_CBR_CAS : ST_ROW;
                    end else begin
                        seq_d.idx = '0;
                        unique case (seq_q.ph)
                            PH_INIT:  begin seq_d.ph = PH_FILL;  seq_d.st = ST_ROW;     end
                            PH_FILL:  begin seq_d.ph = PH_RMW;   seq_d.st = ST_CBR_CAS; end
                            PH_RMW:   begin seq_d.ph = PH_CHECK; seq_d.st = ST_ROW;     end
                            default: begin
                                if (!seq_q.pass) begin
                                    seq_d.pass = 1'b1;
                                    seq_d.ph   = PH_INIT;
                                    seq_d.st   = ST_ROW;
                                end else begin
                                    seq_d.st   = ST_IDLE;
                                    seq_d.done = 1'b1;
                                end
                            end
                        endcase
                    end
                end
                default: seq_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.st   <= ST_IDLE;
            seq_q.ph   <= PH_INIT;
            seq_q.f_ph <= PH_INIT;
        end else begin
            seq_q <= seq_d;
        end
    end

    refctr_pin_drive #(
        .ADDR_W   (ADDR_W),
        .ROW_W    (ROW_W),
        .TEST_COL (TEST_COL)
    ) pins_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .st      (seq_q.st),
        .ph      (seq_q.ph),
        .idx     (seq_q.idx),
        .bg      (seq_q.pass),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o),
        .we_n_o  (we_n_o),
        .addr_o  (addr_o),
        .din_o   (din_o)
    );

    assign done_o       = seq_q.done;
    assign fail_o       = seq_q.fail;
    assign fail_phase_o = seq_q.f_ph;
    assign fail_pass_o  = seq_q.f_pass;
    assign fail_row_o   = seq_q.f_row;

    // Once done, all strobes are released (R8).
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ras_n_o && cas_n_o && we_n_o));

    // Results hold while no new start arrives (R9).
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(fail_o) && $stable(fail_row_o)));

    // The inverted pass only begins after a completed check phase (R7).
    assert_pass_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_q.pass) |-> ($past(seq_q.ph) == PH_CHECK));

endmodule

// File: tb/refctr_test_seq_tb_top.sv
module refctr_test_seq_tb_top;
    localparam int ADDR_W = 11;
    localparam int ROW_W  = 10;
    localparam int NROW   = 1 << ROW_W;
    localparam int COL    = 'h2A5;
    localparam int STEP   = 2;
    localparam int LIMIT  = 195000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic dout = 1'b0;
    logic done, fail, fpass, ras_n, cas_n, we_n, din;
    logic [1:0] fphase;
    logic [ROW_W-1:0] frow;
    logic [ADDR_W-1:0] addr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    refctr_test_seq #(
        .ADDR_W(ADDR_W), .ROW_W(ROW_W), .TEST_COL(COL), .INIT_CYC(8), .STEP_CYC(STEP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .dout_i(dout),
        .done_o(done), .fail_o(fail), .fail_phase_o(fphase), .fail_pass_o(fpass),
        .fail_row_o(frow), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
        .addr_o(addr), .din_o(din)
    );

    // ---------------- behavioural memory with fault injection ----------------
    // mode 0 none, 1 counter bit k stuck 0, 2 counter frozen, 3 cell r stuck 1, 4 cell r stuck 0
    int fmode = 0, fk = 0, frr = 0;
    int ctr = 0;
    bit mem [0:NROW-1];
    bit p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
    bit in_cbr = 1'b0, cas_seen = 1'b0, rd_act = 1'b0;
    int act_row = 0;
    int ro_cnt, ro_err, col_err, wr_cnt, wr_bad, cbr_cnt, rmw_cnt, rmw_bad, rd_cnt, tm_err;
    int gap, min_gap;

    function automatic bit cell_rd(int row, bit v);
        if (fmode == 3 && row == frr) return 1'b1;
        if (fmode == 4 && row == frr) return 1'b0;
        return v;
    endfunction

    task automatic clear_stats();
        ro_cnt = 0; ro_err = 0; col_err = 0; wr_cnt = 0; wr_bad = 0; cbr_cnt = 0;
        rmw_cnt = 0; rmw_bad = 0; rd_cnt = 0; tm_err = 0; min_gap = 1000; gap = 1000;
    endtask

    always @(negedge clk) begin
        gap = gap + 1;
        if (p_ras != ras_n || p_cas != cas_n || p_we != we_n) begin
            if (gap < min_gap) min_gap = gap;
            gap = 0;
        end
        if (!p_ras && ras_n) begin
            if (!in_cbr && !cas_seen) begin
                if (act_row != ro_cnt % 8) ro_err++;
                ro_cnt++;
            end
            in_cbr = 0; cas_seen = 0; rd_act = 0;
        end
        if (p_ras && !ras_n) begin
            if (!cas_n) begin
                if (!we_n) tm_err++;
                act_row = (fmode == 1) ? (ctr & ~(1 << fk)) : ctr;
                if (fmode != 2) ctr = (ctr + 1) % NROW;
                in_cbr = 1; cbr_cnt++;
            end else begin
                act_row = int'(addr[ROW_W-1:0]);
                in_cbr = 0;
            end
        end
        if (!ras_n && p_cas && !cas_n) begin
            cas_seen = 1;
            if (int'(addr) != COL) col_err++;
            if (!we_n) begin
                if (din != ((wr_cnt / NROW) % 2)) wr_bad++;
                mem[act_row] = din; wr_cnt++;
            end else begin
                rd_act = 1;
                if (!in_cbr) rd_cnt++;
            end
        end
        if (!ras_n && !cas_n && rd_act && p_we && !we_n) begin
            if (din != !((rmw_cnt / NROW) % 2)) rmw_bad++;
            mem[act_row] = din; rmw_cnt++; rd_act = 0;
        end
        if (p_cas == 0 && cas_n) rd_act = 0;
        dout = (!ras_n && !cas_n && rd_act) ? cell_rd(act_row, mem[act_row]) : 1'b0;
        p_ras = ras_n; p_cas = cas_n; p_we = we_n;
    end

    // ---------------- reference prediction from the requirements ----------------
    function automatic void predict(input int mode, input int k, input int r, input int s,
                                    output bit f, output int ph, output int ps, output int row);
        bit m [0:NROW-1];
        int c = s;
        int rw;
        bit v;
        f = 0; ph = 0; ps = 0; row = 0;
        for (int p = 0; p < 2; p++) begin
            for (int x = 0; x < NROW; x++) m[x] = p[0];
            for (int i = 0; i < NROW; i++) begin
                rw = (mode == 1) ? (c & ~(1 << k)) : c;
                if (mode != 2) c = (c + 1) % NROW;
                v = m[rw];
                if (mode == 3 && rw == r) v = 1;
                if (mode == 4 && rw == r) v = 0;
                if (v != p[0]) begin f = 1; ph = 2; ps = p; row = i; return; end
                m[rw] = !p[0];
            end
            for (int x = 0; x < NROW; x++) begin
                v = m[x];
                if (mode == 3 && x == r) v = 1;
                if (mode == 4 && x == r) v = 0;
                if (v != !p[0]) begin f = 1; ph = 3; ps = p; row = x; return; end
            end
        end
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(int mode, int k, int r, int s);
        bit ef;
        int eph, eps, erow;
        int all0;
        fmode = mode; fk = k; frr = r; ctr = s;
        clear_stats();
        predict(mode, k, r, s, ef, eph, eps, erow);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R9 done cleared by start", int'(done), 0);
        chk("R9 fail cleared by start", int'(fail), 0);
        while (!done) @(negedge clk);
        chk("R8/R7 fail flag", int'(fail), int'(ef));
        chk("R8 strobes released", int'({ras_n, cas_n, we_n}), 7);
        chk("R5 WE high at CBR RAS fall", tm_err, 0);
        chk("R3 fixed column", col_err, 0);
        chk("R10 strobe spacing", int'(min_gap >= STEP), 1);
        if (ef) begin
            chk("R8 fail phase", int'(fphase), eph);
            chk("R8 fail pass", int'(fpass), eps);
            chk("R8 fail row", int'(frow), erow);
            repeat (3) @(negedge clk);
            chk("R9 result holds", int'(frow), erow);
        end else begin
            chk("R2 RAS-only count", ro_cnt, 16);
            chk("R2 RAS-only rows", ro_err, 0);
            chk("R4 fill writes", wr_cnt, 2 * NROW);
            chk("R4 fill data", wr_bad, 0);
            chk("R5 counter cycles", cbr_cnt, 2 * NROW);
            chk("R5 complement writes", rmw_cnt, 2 * NROW);
            chk("R5 complement data", rmw_bad, 0);
            chk("R6 check reads", rd_cnt, 2 * NROW);
            all0 = 0;
            for (int x = 0; x < NROW; x++) if (mem[x]) all0++;
            chk("R7 final cells zero", all0, 0);
        end
    endtask

    initial begin
        void'($urandom(32'h1bad5eed));
        repeat (3) @(negedge clk);
        chk("R1 strobes idle in reset", int'({ras_n, cas_n, we_n}), 7);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 strobes idle", int'({ras_n, cas_n, we_n}), 7);
        chk("R1 done low", int'(done), 0);
        chk("R1 fail low", int'(fail), 0);
        run(0, 0, 0, int'($urandom_range(NROW - 1)));
        run(2, 0, 0, int'($urandom_range(NROW - 1)));
        run(1, int'($urandom_range(5)), 0, int'($urandom_range(NROW - 1)));
        run(3, 0, int'($urandom_range(NROW - 1)), int'($urandom_range(NROW - 1)));
        run(4, 0, int'($urandom_range(NROW - 1)), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule